// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block sits next to the byte engine of an I2C slave and keeps a small set of status flags that host software reads. It samples the already synchronized SCL and SDA lines once per clock. A bus start is SDA falling while SCL stays high, and a bus stop is SDA rising while SCL stays high. The byte engine sends single-cycle strobes for received bytes, bytes loaded for transmit, address matches, sampled acknowledge bits and host reads of the data buffer. From these strobes the block keeps flags for direction, data versus address, buffer occupancy and address reload.

All flags are registered. A condition present on the inputs at a clock edge shows on the outputs just after that edge. When the module enable is low, every flag is held at zero and bus conditions are ignored.

Top module: `i2c_slave_bus_status`

## Requirements
- R1: When the previous sample had SCL=1 and SDA=1 and the current sample has SCL=1 and SDA=0, start_o becomes 1 and stop_o becomes 0 after that edge. This covers repeated starts as well.
- R2: When the previous sample had SCL=1 and SDA=0 and the current sample has SCL=1 and SDA=1, stop_o becomes 1 and start_o becomes 0 after that edge. start_o and stop_o are never both 1.
- R3: While en_i is 0, all output flags read 0 one edge later, and start and stop patterns on the lines have no effect.
- R4: data_o takes rx_is_data_i on a rx_done_i strobe (1 = data, 0 = address). data_o becomes 1 on a tx_load_i strobe. If both strobes arrive together, rx_done_i wins.
- R5: On adr_match_i, the R/W bit adr_rw_i is captured, and read_o shows it (1 = read, 0 = write) from the next edge on.
- R6: A start, a stop, or ack_smp_i with nack_i=1 closes the R/W window, and read_o then reads 0 until the next address match. These clearing events take priority over a match in the same cycle.
- R7: With ten_bit_i=1, every adr_match_i strobe sets upd_adr_o. An adr_wr_i strobe clears it. A set in the same cycle wins over a clear.
- R8: rx_done_i sets buf_full_o and selects receive mode. In receive mode, buf_rd_i clears buf_full_o. Acknowledge strobes do not clear it in this mode.
- R9: tx_load_i sets buf_full_o and selects transmit mode. In transmit mode, the next ack_smp_i clears buf_full_o, and buf_rd_i has no effect. A set strobe beats any clear in the same cycle.
- R10: After reset, all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| en_i | input | 1 | module enable |
| scl_i | input | 1 | synchronized SCL |
| sda_i | input | 1 | synchronized SDA |
| rx_done_i | input | 1 | strobe: a byte has been received into the buffer |
| rx_is_data_i | input | 1 | with rx_done_i: 1 = data byte, 0 = address byte |
| tx_load_i | input | 1 | strobe: a byte has been loaded for transmit |
| adr_match_i | input | 1 | strobe: the address byte matched |
| adr_rw_i | input | 1 | R/W bit of the matched address byte |
| ten_bit_i | input | 1 | 10-bit addressing mode |
| adr_wr_i | input | 1 | strobe: software wrote the address compare register |
| ack_smp_i | input | 1 | strobe: the acknowledge bit was sampled |
| nack_i | input | 1 | with ack_smp_i: 1 = NACK |
| buf_rd_i | input | 1 | strobe: host read the data buffer |
| start_o | output | 1 | a start was the last bus condition |
| stop_o | output | 1 | a stop was the last bus condition |
| data_o | output | 1 | the last byte was data (1) or an address (0) |
| read_o | output | 1 | R/W bit of the last match, 0 outside its window |
| upd_adr_o | output | 1 | software must reload the compare address |
| buf_full_o | output | 1 | the data buffer holds a byte |

## Verification
Directed sequences come first and check one behaviour each:
- a clean start, an address phase, a data read, a transmit with NACK, and a stop;
- a 10-bit match followed by an address write;
- a start followed by the enable dropping, to show that disable wins over a held bus condition.

Random SCL and SDA levels, with SCL biased high, then create starts, repeated starts, stops and SDA moves while SCL is low. These runs separate true bus conditions from ordinary data changes. Random strobes, mixed with occasional enable drops, exercise the same-cycle priorities between set and clear events on the direction, address-reload and buffer flags.

// File: rtl/i2c_slave_bus_status.sv
module i2c_slave_bus_status (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic rx_done_i,
  input  logic rx_is_data_i,
  input  logic tx_load_i,
  input  logic adr_match_i,
  input  logic adr_rw_i,
  input  logic ten_bit_i,
  input  logic adr_wr_i,
  input  logic ack_smp_i,
  input  logic nack_i,
  input  logic buf_rd_i,
  output logic start_o,
  output logic stop_o,
  output logic data_o,
  output logic read_o,
  output logic upd_adr_o,
  output logic buf_full_o
);

  logic scl_q, sda_q;
  logic st_r, sp_r, da_r, rw_bit_r, rw_ok_r, ua_r, bf_r, txm_r;
  logic start_det, stop_det, win_close;

  assign start_det = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_det  = scl_q & scl_i & ~sda_q & sda_i;
  assign win_close = start_det | stop_det | (ack_smp_i & nack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r <= 1'b0; sp_r <= 1'b0; da_r <= 1'b0; rw_bit_r <= 1'b0;
      rw_ok_r <= 1'b0; ua_r <= 1'b0; bf_r <= 1'b0; txm_r <= 1'b0;
    end else if (!en_i) begin
      st_r <= 1'b0; sp_r <= 1'b0; da_r <= 1'b0; rw_bit_r <= 1'b0;
      rw_ok_r <= 1'b0; ua_r <= 1'b0; bf_r <= 1'b0; txm_r <= 1'b0;
    end else begin
      if (start_det) begin
        st_r <= 1'b1;
        sp_r <= 1'b0;
      end else if (stop_det) begin
        sp_r <= 1'b1;
        st_r <= 1'b0;
      end

      if (rx_done_i)      da_r <= rx_is_data_i;
      else if (tx_load_i) da_r <= 1'b1;

      if (win_close) begin
        rw_ok_r  <= 1'b0;
        rw_bit_r <= 1'b0;
      end else if (adr_match_i) begin
        rw_ok_r  <= 1'b1;
        rw_bit_r <= adr_rw_i;
      end

      if (adr_match_i && ten_bit_i) ua_r <= 1'b1;
      else if (adr_wr_i)            ua_r <= 1'b0;

      if (rx_done_i)      txm_r <= 1'b0;
      else if (tx_load_i) txm_r <= 1'b1;

      if (rx_done_i || tx_load_i)     bf_r <= 1'b1;
      else if (!txm_r && buf_rd_i)    bf_r <= 1'b0;
      else if (txm_r && ack_smp_i)    bf_r <= 1'b0;
    end
  end

  assign start_o    = st_r;
  assign stop_o     = sp_r;
  assign data_o     = da_r;
  assign read_o     = rw_ok_r & rw_bit_r;
  assign upd_adr_o  = ua_r;
  assign buf_full_o = bf_r;

endmodule

// File: rtl/i2c_slave_bus_status_chk.sv
module i2c_slave_bus_status_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic start_det,
  input logic stop_det,
  input logic adr_match_i,
  input logic adr_rw_i,
  input logic ten_bit_i,
  input logic ack_smp_i,
  input logic nack_i,
  input logic buf_rd_i,
  input logic rx_done_i,
  input logic tx_load_i,
  input logic txm_r,
  input logic start_o,
  input logic stop_o,
  input logic read_o,
  input logic upd_adr_o,
  input logic buf_full_o
);

  a_r1_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && start_det) |=> (start_o && !stop_o));

  a_r2_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && stop_det) |=> (stop_o && !start_o));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));

  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!start_o && !stop_o && !read_o && !upd_adr_o && !buf_full_o));

  a_r5_rw_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && adr_match_i && !start_det && !stop_det && !(ack_smp_i && nack_i))
      |=> (read_o == $past(adr_rw_i)));

  a_r6_window_close: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (start_det || stop_det || (ack_smp_i && nack_i))) |=> !read_o);

  a_r7_ua_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && adr_match_i && ten_bit_i) |=> upd_adr_o);

  a_r8_rx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !txm_r && buf_rd_i && !rx_done_i && !tx_load_i) |=> !buf_full_o);

  a_r9_tx_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && txm_r && buf_full_o && buf_rd_i && !ack_smp_i && !rx_done_i) |=> buf_full_o);

endmodule

bind i2c_slave_bus_status i2c_slave_bus_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i),
  .start_det(start_det), .stop_det(stop_det),
  .adr_match_i(adr_match_i), .adr_rw_i(adr_rw_i), .ten_bit_i(ten_bit_i),
  .ack_smp_i(ack_smp_i), .nack_i(nack_i), .buf_rd_i(buf_rd_i),
  .rx_done_i(rx_done_i), .tx_load_i(tx_load_i), .txm_r(txm_r),
  .start_o(start_o), .stop_o(stop_o), .read_o(read_o),
  .upd_adr_o(upd_adr_o), .buf_full_o(buf_full_o)
);

// File: tb/i2c_slave_bus_status_tb_top.sv
module i2c_slave_bus_status_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, scl = 1'b1, sda = 1'b1;
  logic rx_done = 0, rx_is_data = 0, tx_load = 0, adr_match = 0, adr_rw = 0;
  logic ten_bit = 0, adr_wr = 0, ack_smp = 0, nack = 0, buf_rd = 0;
  logic start_o, stop_o, data_o, read_o, upd_adr_o, buf_full_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_slave_bus_status dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
    .rx_done_i(rx_done), .rx_is_data_i(rx_is_data), .tx_load_i(tx_load),
    .adr_match_i(adr_match), .adr_rw_i(adr_rw), .ten_bit_i(ten_bit),
    .adr_wr_i(adr_wr), .ack_smp_i(ack_smp), .nack_i(nack), .buf_rd_i(buf_rd),
    .start_o(start_o), .stop_o(stop_o), .data_o(data_o), .read_o(read_o),
    .upd_adr_o(upd_adr_o), .buf_full_o(buf_full_o)
  );

  logic m_scl = 1, m_sda = 1;
  logic m_st = 0, m_sp = 0, m_da = 0, m_rw = 0, m_ua = 0, m_bf = 0, m_tx = 0;

  task automatic model_step();
    logic s_det, p_det;
    s_det = m_scl && scl && m_sda && !sda;
    p_det = m_scl && scl && !m_sda && sda;
    m_scl = scl;
    m_sda = sda;
    if (!en) begin
      {m_st, m_sp, m_da, m_rw, m_ua, m_bf, m_tx} = '0;
    end else begin
      if (s_det) begin m_st = 1; m_sp = 0; end
      else if (p_det) begin m_sp = 1; m_st = 0; end
      if (rx_done) m_da = rx_is_data; else if (tx_load) m_da = 1;
      if (s_det || p_det || (ack_smp && nack)) m_rw = 0;
      else if (adr_match) m_rw = adr_rw;
      if (adr_match && ten_bit) m_ua = 1; else if (adr_wr) m_ua = 0;
      if (rx_done || tx_load) m_bf = 1;
      else if (!m_tx && buf_rd) m_bf = 0;
      else if (m_tx && ack_smp) m_bf = 0;
      if (rx_done) m_tx = 0; else if (tx_load) m_tx = 1;
    end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 start_o", start_o, m_st);
    chk("R2 stop_o", stop_o, m_sp);
    chk("R4 data_o", data_o, m_da);
    chk("R5/R6 read_o", read_o, m_rw);
    chk("R7 upd_adr_o", upd_adr_o, m_ua);
    chk("R8/R9 buf_full_o", buf_full_o, m_bf);
  endtask

  task automatic clr_strobes();
    rx_done = 0; tx_load = 0; adr_match = 0; adr_wr = 0; ack_smp = 0; buf_rd = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    clr_strobes();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    chk("R10 reset start", start_o, 1'b0);
    chk("R10 reset stop", stop_o, 1'b0);
    chk("R10 reset bf", buf_full_o, 1'b0);
    chk("R10 reset ua", upd_adr_o, 1'b0);
    rst_n = 1;

    cycle();
    sda = 0; cycle();
    chk("R1 start seen", start_o, 1'b1);
    scl = 0; cycle();
    rx_done = 1; rx_is_data = 0; adr_match = 1; adr_rw = 1; cycle();
    chk("R5 read captured", read_o, 1'b1);
    chk("R4 address byte", data_o, 1'b0);
    chk("R8 rx full", buf_full_o, 1'b1);
    buf_rd = 1; cycle();
    chk("R8 read empties", buf_full_o, 1'b0);
    tx_load = 1; cycle();
    chk("R9 tx full", buf_full_o, 1'b1);
    chk("R4 tx data", data_o, 1'b1);
    buf_rd = 1; cycle();
    chk("R9 buf_rd ignored", buf_full_o, 1'b1);
    ack_smp = 1; nack = 1; cycle();
    chk("R9 ack empties", buf_full_o, 1'b0);
    chk("R6 nack closes", read_o, 1'b0);
    nack = 0;
    sda = 0; cycle();
    scl = 1; cycle();
    sda = 1; cycle();
    chk("R2 stop seen", stop_o, 1'b1);
    chk("R2 start cleared", start_o, 1'b0);
    ten_bit = 1; adr_match = 1; adr_rw = 0; cycle();
    chk("R7 ua set", upd_adr_o, 1'b1);
    adr_wr = 1; cycle();
    chk("R7 ua cleared", upd_adr_o, 1'b0);
    ten_bit = 0;
    sda = 0; cycle();
    chk("R1 start again", start_o, 1'b1);
    en = 0; cycle();
    chk("R3 disable clears start", start_o, 1'b0);
    sda = 1; cycle();
    chk("R3 stop ignored", stop_o, 1'b0);
    en = 1; cycle();

    for (int i = 0; i < 4000; i++) begin
      scl        = ($urandom % 4) != 0;
      sda        = ($urandom % 3) != 0;
      en         = ($urandom % 40) != 0;
      rx_done    = ($urandom % 8) == 0;
      rx_is_data = $urandom % 2;
      tx_load    = ($urandom % 9) == 0;
      adr_match  = ($urandom % 7) == 0;
      adr_rw     = $urandom % 2;
      ten_bit    = ($urandom % 3) == 0;
      adr_wr     = ($urandom % 6) == 0;
      ack_smp    = ($urandom % 6) == 0;
      nack       = $urandom % 2;
      buf_rd     = ($urandom % 5) == 0;
      cycle();
    end

    finished = 1;
    report();
  end

endmodule